// File: doc/BRIEF.md
# Split-Width Adder with Constant Upper Operand

This block is a purely combinational two-operand adder for the last addition of a residue-to-binary converter. There, one operand is full width while the other is known only in its low bits. Its high bits are a fixed pattern chosen when the design is built. The adder splits the work along that boundary. The low `LO_W` positions, where both operands change, use a Brent-Kung parallel-prefix carry network. The upper `HI_W` positions, where one input is a constant, use a short ripple of two-gate cells fed by the prefix section's carry out.

A caller that needs subtraction passes the bitwise inverse of the subtrahend and drives the carry-in high. The constant pattern then holds the inverted upper bits of the subtrahend. The block itself only adds. There is no clock, no reset and no storage. Outputs follow the inputs after the combinational delay.

Top module: `hybrid_const_adder`

## Requirements
- R1: `{cout_o, sum_o}` equals `a_i + {HI_CONST, b_lo_i} + cin_i`, computed exactly in `LO_W+HI_W+1` bits.
- R2: Driving `cin_i` high raises the result by exactly one compared with `cin_i` low for the same operands. This includes the case where that one ripples through every bit into `cout_o`.
- R3: The low `LO_W` bits of `sum_o` depend only on `a_i[LO_W-1:0]`, `b_lo_i` and `cin_i`. Changing `a_i[LO_W+HI_W-1:LO_W]` leaves them unchanged.
- R4: The upper section receives the prefix section's carry out. When `a_i[LO_W-1:0] + b_lo_i + cin_i` reaches `2**LO_W`, the upper field of `sum_o` equals `a_i` upper field plus `HI_CONST` plus one.
- R5: With all inputs zero, `sum_o` equals `{HI_CONST, LO_W zeros}` and `cout_o` is 0.
- R6: `cout_o` is 1 exactly when the full-width sum is at least `2**(LO_W+HI_W)`. With all inputs at all ones, `cout_o` is 1.
- R7: For a subtrahend x whose upper field equals `~HI_CONST`, driving `b_lo_i = ~x[LO_W-1:0]` and `cin_i = 1` yields `sum_o = a_i - x` modulo `2**(LO_W+HI_W)`. In that case `cout_o = 1` exactly when `a_i >= x`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | LO_W+HI_W | Full-width operand |
| b_lo_i | input | LO_W | Variable low field of the second operand (upper field is `HI_CONST`) |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | LO_W+HI_W | Sum bits |
| cout_o | output | 1 | Carry out of the top bit |

## Verification
The block holds no state. A wrong carry in the prefix tree or a miswired constant cell therefore shows at the outputs as soon as the inputs change, with no delay. The fault appears only for input patterns that exercise that carry path. A faulty prefix node shows in the low sum bits and, through the boundary carry, in the upper field. A cell built for the wrong constant value corrupts its own sum bit even with a zero carry. For this reason, the corner vectors force carries to start at bit 0 and travel across the section boundary to `cout_o`.

// File: rtl/hca_pkg.sv
package hca_pkg;
    // number of Brent-Kung levels for a given width
    function automatic int bk_levels(input int width);
        return $clog2(width);
    endfunction

    // up-sweep levels plus down-sweep levels
    function automatic int bk_stages(input int width);
        return 2 * $clog2(width) - 1;
    endfunction
endpackage

// File: rtl/hca_bk_prefix.sv
module hca_bk_prefix #(
    parameter int W = 16
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);
    import hca_pkg::*;

    localparam int LV = bk_levels(W);
    localparam int NS = bk_stages(W);

    logic [W-1:0] prop;
    logic [W-1:0] gen;
    logic [W-1:0] g_st [NS+1];
    logic [W-1:0] p_st [NS+1];
    logic [W-1:0] carry_in;

    // preprocessing: carry-in folded into the generate of bit 0
    assign prop = x_i ^ y_i;
    assign gen  = x_i & y_i;
    assign g_st[0] = {gen[W-1:1], gen[0] | (prop[0] & cin_i)};
    assign p_st[0] = prop;

    // carry generation network
    for (genvar t = 0; t < NS; t++) begin : g_stage
        for (genvar i = 0; i < W; i++) begin : g_bit
            if (t < LV) begin : g_up
                localparam int D = 2 ** t;
                if (((i + 1) % (2 * D)) == 0) begin : g_node
                    assign g_st[t+1][i] = g_st[t][i] | (p_st[t][i] & g_st[t][i-D]);
                    assign p_st[t+1][i] = p_st[t][i] & p_st[t][i-D];
                end else begin : g_pass
                    assign g_st[t+1][i] = g_st[t][i];
                    assign p_st[t+1][i] = p_st[t][i];
                end
            end else begin : g_down
                localparam int D = 2 ** (LV - 2 - (t - LV));
                if ((((i + 1) % (2 * D)) == D) && ((i + 1) >= 3 * D)) begin : g_node
                    assign g_st[t+1][i] = g_st[t][i] | (p_st[t][i] & g_st[t][i-D]);
                    assign p_st[t+1][i] = p_st[t][i] & p_st[t][i-D];
                end else begin : g_pass
                    assign g_st[t+1][i] = g_st[t][i];
                    assign p_st[t+1][i] = p_st[t][i];
                end
            end
        end
    end

    // postprocessing
    assign carry_in = {g_st[NS][W-2:0], cin_i};
    assign sum_o    = prop ^ carry_in;
    assign cout_o   = g_st[NS][W-1];
endmodule

// File: rtl/hca_const_ripple.sv
module hca_const_ripple #(
    parameter int          W     = 8,
    parameter logic [W-1:0] CBITS = '0
) (
    input  logic [W-1:0] x_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);
    logic [W:0] c;

    assign c[0] = cin_i;

    for (genvar j = 0; j < W; j++) begin : g_cell
        if (CBITS[j]) begin : g_one
            assign sum_o[j] = ~(x_i[j] ^ c[j]);
            assign c[j+1]   = x_i[j] | c[j];
        end else begin : g_zero
            assign sum_o[j] = x_i[j] ^ c[j];
            assign c[j+1]   = x_i[j] & c[j];
        end
    end

    assign cout_o = c[W];
endmodule

// File: rtl/hybrid_const_adder.sv
module hybrid_const_adder #(
    parameter int                LO_W     = 16,
    parameter int                HI_W     = 8,
    parameter logic [HI_W-1:0]   HI_CONST = 8'hB2
) (
    input  logic [LO_W+HI_W-1:0] a_i,
    input  logic [LO_W-1:0]      b_lo_i,
    input  logic                 cin_i,
    output logic [LO_W+HI_W-1:0] sum_o,
    output logic                 cout_o
);
    localparam int W = LO_W + HI_W;

    logic            lo_carry;
    logic [LO_W-1:0] lo_sum;
    logic [HI_W-1:0] hi_sum;

    hca_bk_prefix #(.W(LO_W)) i_lo (
        .x_i    (a_i[LO_W-1:0]),
        .y_i    (b_lo_i),
        .cin_i  (cin_i),
        .sum_o  (lo_sum),
        .cout_o (lo_carry)
    );

    hca_const_ripple #(.W(HI_W), .CBITS(HI_CONST)) i_hi (
        .x_i    (a_i[W-1:LO_W]),
        .cin_i  (lo_carry),
        .sum_o  (hi_sum),
        .cout_o (cout_o)
    );

    assign sum_o = {hi_sum, lo_sum};
endmodule

// File: rtl/hca_checker.sv
module hca_checker #(
    parameter int              LO_W     = 16,
    parameter int              HI_W     = 8,
    parameter logic [HI_W-1:0] HI_CONST = 8'hB2
) (
    input logic [LO_W+HI_W-1:0] a_i,
    input logic [LO_W-1:0]      b_lo_i,
    input logic                 cin_i,
    input logic [LO_W+HI_W-1:0] sum_o,
    input logic                 cout_o,
    input logic                 lo_carry
);
    localparam int W = LO_W + HI_W;

    logic [LO_W:0] lo_ref;
    logic [HI_W:0] hi_ref;
    logic [W:0]    full_ref;

    always_comb begin
        lo_ref   = {1'b0, a_i[LO_W-1:0]} + {1'b0, b_lo_i} + {{LO_W{1'b0}}, cin_i};
        hi_ref   = {1'b0, a_i[W-1:LO_W]} + {1'b0, HI_CONST} + {{HI_W{1'b0}}, lo_carry};
        full_ref = {1'b0, a_i} + {1'b0, HI_CONST, b_lo_i} + {{W{1'b0}}, cin_i};

        p_low_sum_r3: assert ({lo_carry, sum_o[LO_W-1:0]} == lo_ref)
            else $error("low section result wrong");
        p_boundary_carry_r4: assert ({cout_o, sum_o[W-1:LO_W]} == hi_ref)
            else $error("upper section does not follow boundary carry");
        p_full_sum_r1: assert ({cout_o, sum_o} == full_ref)
            else $error("full sum wrong");
        p_no_overflow_r6: assert (cout_o == full_ref[W])
            else $error("carry out wrong");
        if (a_i == '0 && b_lo_i == '0 && !cin_i) begin
            p_zero_in_r5: assert (sum_o == {HI_CONST, {LO_W{1'b0}}} && !cout_o)
                else $error("zero inputs give wrong result");
        end
    end
endmodule

bind hybrid_const_adder hca_checker #(
    .LO_W(LO_W), .HI_W(HI_W), .HI_CONST(HI_CONST)
) i_chk (
    .a_i(a_i), .b_lo_i(b_lo_i), .cin_i(cin_i),
    .sum_o(sum_o), .cout_o(cout_o), .lo_carry(lo_carry)
);

// File: tb/test_hybrid_const_adder.sv
module test_hybrid_const_adder;
    localparam int              LO_W  = 16;
    localparam int              HI_W  = 8;
    localparam int              W     = LO_W + HI_W;
    localparam logic [HI_W-1:0] CONST = 8'hB2;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic [W-1:0]    a;
    logic [LO_W-1:0] b;
    logic            cin;
    logic [W-1:0]    sum;
    logic            cout;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    hybrid_const_adder #(.LO_W(LO_W), .HI_W(HI_W), .HI_CONST(CONST)) i_hybrid_const_adder (
        .a_i(a), .b_lo_i(b), .cin_i(cin), .sum_o(sum), .cout_o(cout)
    );

    function automatic longint ref_sum(input longint av, input longint bv, input longint cv);
        longint full_b;
        full_b = (longint'(CONST) << LO_W) + bv;
        return (av + full_b + cv) & ((64'd1 << (W + 1)) - 1);
    endfunction

    task automatic report(input string req, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // drive on a rising edge, sample on the following falling edge
    task automatic apply(input longint av, input longint bv, input bit cv);
        @(posedge clk);
        a   = av[W-1:0];
        b   = bv[LO_W-1:0];
        cin = cv;
        @(negedge clk);
    endtask

    task automatic run_vec(input string req, input longint av, input longint bv, input bit cv);
        apply(av, bv, cv);
        report(req, {cout, sum}, ref_sum(av, bv, longint'(cv)));
    endtask

    initial begin
        longint amask;
        longint lmask;
        longint lo0;
        longint x;
        longint a_lo;
        amask = (64'd1 << W) - 1;
        lmask = (64'd1 << LO_W) - 1;
        a = '0; b = '0; cin = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R5: all-zero inputs
        report("R5 zero", {cout, sum}, longint'(CONST) << LO_W);
        run_vec("R1 basic", 64'h000123, 64'h0456, 1'b0);
        // R6: all ones
        run_vec("R6 all ones", amask, lmask, 1'b1);
        report("R6 cout all ones", longint'(cout), 1);
        // R2: carry-in ripples through whole width
        begin
            longint ahigh;
            ahigh = longint'(~CONST) & ((64'd1 << HI_W) - 1);
            apply((ahigh << LO_W) | lmask, 0, 1'b0);
            lo0 = {cout, sum};
            apply((ahigh << LO_W) | lmask, 0, 1'b1);
            report("R2 ripple", {cout, sum}, lo0 + 1);
            report("R6 ripple cout", longint'(cout), 1);
        end
        // R4: boundary carry
        apply(64'h00FFFF, 64'h0001, 1'b0);
        report("R4 boundary", longint'(sum[W-1:LO_W]), (longint'(CONST) + 1) & 8'hFF);
        apply(64'h00FFFE, 64'h0001, 1'b0);
        report("R4 no boundary", longint'(sum[W-1:LO_W]), longint'(CONST));
        // R3: upper bits of a do not touch low sum
        apply(64'h3C1234, 64'h8765, 1'b1);
        lo0 = longint'(sum[LO_W-1:0]);
        apply(64'hC31234, 64'h8765, 1'b1);
        report("R3 low independent", longint'(sum[LO_W-1:0]), lo0);
        // R1 random
        for (int i = 0; i < 60; i++) begin
            run_vec("R1 random", longint'($urandom) & amask, longint'($urandom) & lmask, 1'($urandom));
        end
        // R7 subtraction
        for (int i = 0; i < 12; i++) begin
            longint av;
            x    = ((longint'(~CONST) & 8'hFF) << LO_W) | (longint'($urandom) & lmask);
            a_lo = longint'($urandom) & lmask;
            av   = (i % 3 == 0) ? x : ((i % 2 == 0) ? (x | 64'hFF0000) & amask : a_lo);
            apply(av, (~x) & lmask, 1'b1);
            report("R7 difference", longint'(sum), (av - x) & amask);
            report("R7 borrow", longint'(cout), (av >= x) ? 1 : 0);
        end
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule